// File: doc/BRIEF.md
# Supervisory reset sequencer

This block drives the active-low system reset of a board-level controller from a supply-good flag and a manual reset button. It keeps reset asserted from power-up and during any supply dip. Reset is let go only after the supply flag has stayed good, without interruption, for a release timeout. One selector input chooses between a short and a long timeout. A second output, the low-line flag, follows the supply flag at once and has no timeout, so software can tell a brownout from the tail of a reset.

The manual reset button is filtered by a tick-based debouncer before it can take effect. While the debounced button is held, reset stays asserted. After the button is released, the same stretch timer runs one full timeout before reset is let go. A bus-hold output is asserted over the whole reset period, so the host interface ignores traffic during that time. All timing counts a one-millisecond tick enable, not the clock, so a testbench can compress time.

Top module: `rst_sequencer`

## Requirements
- R1: After `rst_ni` is deasserted with the supply good, `sys_rst_no` stays low and is released only once the full selected timeout has elapsed.
- R2: `sys_rst_no` goes low in the same cycle that `supply_ok_i` goes low, and stays low while `supply_ok_i` is low.
- R3: Reset is released only after `supply_ok_i` has been high without a break for the timeout. Any low cycle during the count restarts it from zero.
- R4: `tmo_sel_i` = 0 selects a timeout of `SHORT_MS` ticks (default 150). `tmo_sel_i` = 1 selects `LONG_MS` ticks (default 800).
- R5: `tmo_sel_i` is sampled in the cycle the count starts. A change later in the count does not alter the length of that count.
- R6: `low_line_no` equals `supply_ok_i` combinationally, with no timeout and no register.
- R7: The manual reset input `man_rst_ni` changes its filtered level only after it has differed from that level for `DEB_MS` consecutive ticks (default 10). Shorter bounces have no effect on `sys_rst_no`.
- R8: While the filtered button is low, reset is held. After it returns high, reset stays low for one full timeout.
- R9: `bus_hold_o` is high exactly when `sys_rst_no` is low.
- R10: Counters advance only in cycles where `tick_i` is high. With no ticks, reset is never released and the button filter never changes level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| tick_i | input | 1 | One-millisecond tick enable |
| supply_ok_i | input | 1 | Supply comparator flag, high when above threshold |
| man_rst_ni | input | 1 | Manual reset button, active low, unfiltered |
| tmo_sel_i | input | 1 | Timeout select: 0 short, 1 long |
| sys_rst_no | output | 1 | System reset, active low |
| low_line_no | output | 1 | Undelayed low-supply flag, active low |
| bus_hold_o | output | 1 | Bus communication inhibit, high during reset |

## Verification
Directed patterns cover power-up, a single supply dip, a dip that lands partway through a count, and a selector flip during a count. Each check asserts an exact release tick, so a timer that resumes instead of restarting, or that reads the selector late, lands on the wrong tick. Button patterns compare bounces shorter than the filter window against a clean press and release; this separates a working filter from a pass-through, and a stretched release from an immediate one. Random runs vary the tick density, the selector and the dip length. Every release is measured in ticks, not cycles, so a counter that counts clocks is caught.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {PH_HOLD, PH_COUNT, PH_RUN} rst_phase_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rst_debounce.sv
module rst_debounce #(
  parameter int unsigned DEB_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned W = rst_seq_pkg::cnt_width(DEB_MS);
  localparam logic [W-1:0] LAST = W'(DEB_MS - 1);

  logic         lvl_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        lvl_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;

  AST_DB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(tick_i)); // R10
  AST_DB_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R7
  AST_DB_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == lvl_q) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned SHORT_MS = 150,
  parameter int unsigned LONG_MS  = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic sel_i,
  output logic active_o
);
  import rst_seq_pkg::*;

  localparam int unsigned MAXV = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int unsigned CW   = cnt_width(MAXV);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_MS - 1);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_MS - 1);

  rst_phase_e    ph_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] lim;

  assign lim = long_q ? LIM_L : LIM_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_HOLD;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (hold_i) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_HOLD: begin
          ph_q   <= PH_COUNT;
          long_q <= sel_i;   // latched once per count
          cnt_q  <= '0;
        end
        PH_COUNT: if (tick_i) begin
          if (cnt_q == lim) ph_q <= PH_RUN;
          else              cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // hold asserts reset in the same cycle, not one later
  assign active_o = (ph_q != PH_RUN) | hold_i;

  AST_HOLD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (ph_q == PH_HOLD && cnt_q == '0)); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RUN && $past(ph_q) != PH_RUN) |-> $past(tick_i)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_COUNT) |-> (cnt_q <= lim)); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_COUNT && $past(ph_q) == PH_COUNT) |-> $stable(long_q)); // R5
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int unsigned SHORT_MS = 150,
  parameter int unsigned LONG_MS  = 800,
  parameter int unsigned DEB_MS   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic man_rst_ni,
  input  logic tmo_sel_i,
  output logic sys_rst_no,
  output logic low_line_no,
  output logic bus_hold_o
);
  logic btn_lvl;
  logic hold;
  logic active;

  rst_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .raw_i   (man_rst_ni),
    .level_o (btn_lvl)
  );

  assign hold = ~supply_ok_i | ~btn_lvl;

  rst_stretch #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_str (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .hold_i   (hold),
    .sel_i    (tmo_sel_i),
    .active_o (active)
  );

  assign sys_rst_no  = ~active;
  assign bus_hold_o  = active;
  assign low_line_no = supply_ok_i;

  AST_LOWLINE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_line_no |-> !sys_rst_no); // R2
  AST_NO_RELEASE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(tick_i)); // R10
endmodule

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int unsigned SH  = 12;
  localparam int unsigned LG  = 40;
  localparam int unsigned DEB = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic supply_ok_i = 1'b1;
  logic man_rst_ni = 1'b1;
  logic tmo_sel_i = 1'b0;
  logic sys_rst_no, low_line_no, bus_hold_o;

  int total = 0;
  int fails = 0;
  int tick_cnt = 0;
  int tick_den = 1;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_sequencer #(.SHORT_MS(SH), .LONG_MS(LG), .DEB_MS(DEB)) u_rst_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .man_rst_ni(man_rst_ni), .tmo_sel_i(tmo_sel_i),
    .sys_rst_no(sys_rst_no), .low_line_no(low_line_no), .bus_hold_o(bus_hold_o)
  );

  function automatic int exp_lim(input logic s);
    return s ? LG : SH;
  endfunction

  function automatic logic gen_tick(input int den);
    if (den == 0) return 1'b0;
    if (den == 1) return 1'b1;
    return ($urandom % den) == 0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (tick_i) tick_cnt++;
    @(negedge clk);
    tick_i = gen_tick(tick_den);
  endtask

  // from the negedge after the start edge: release must land on tick lim
  task automatic wait_count(input int lim, input string req);
    bit early = 1'b0;
    while (tick_cnt < lim) begin
      #1;
      if (sys_rst_no !== 1'b0) early = 1'b1;
      step();
    end
    #1;
    chk(req, early, 1'b0);
    chk(req, sys_rst_no, 1'b1);
    chk("R9", bus_hold_o, 1'b0);
  endtask

  task automatic wait_release(input int lim, input string req);
    step();
    tick_cnt = 0;
    wait_count(lim, req);
  endtask

  task automatic dip(input int n);
    supply_ok_i = 1'b0;
    #1;
    chk("R6", low_line_no, 1'b0);
    chk("R2", sys_rst_no, 1'b0);
    for (int i = 0; i < n; i++) step();
    #1;
    chk("R2", sys_rst_no, 1'b0);
    supply_ok_i = 1'b1;
    #1;
    chk("R6", low_line_no, 1'b1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    bit hi_bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", sys_rst_no, 1'b0);
    chk("R9", bus_hold_o, 1'b1);
    chk("R6", low_line_no, 1'b1);
    rst_ni = 1'b1;
    wait_release(SH, "R1");

    // plain dip, short timeout
    dip(3);
    #1 chk("R3", sys_rst_no, 1'b0);
    wait_release(SH, "R2");

    // dip in the middle of a count restarts it
    dip(2);
    step(); tick_cnt = 0;
    repeat (8) step();
    dip(1);
    wait_release(SH, "R3");

    // long timeout
    tmo_sel_i = 1'b1;
    dip(2);
    wait_release(LG, "R4");

    // selector flips mid-count are ignored
    tmo_sel_i = 1'b0;
    dip(2);
    step(); tick_cnt = 0;
    tmo_sel_i = 1'b1;
    wait_count(SH, "R5");
    dip(2);
    step(); tick_cnt = 0;
    tmo_sel_i = 1'b0;
    wait_count(LG, "R5");

    // no ticks: nothing advances
    tick_den = 0;
    tick_i = 1'b0;
    dip(2);
    man_rst_ni = 1'b0;
    repeat (60) step();
    #1 chk("R10", sys_rst_no, 1'b0);
    man_rst_ni = 1'b1;
    repeat (2) step();
    tick_den = 1;
    tick_i = 1'b1;
    tick_cnt = 0;
    wait_count(SH, "R10");

    // bounces shorter than the filter window
    for (int b = 0; b < 4; b++) begin
      man_rst_ni = 1'b0;
      repeat (DEB - 2) step();
      man_rst_ni = 1'b1;
      step();
    end
    #1;
    chk("R7", sys_rst_no, 1'b1);
    chk("R9", bus_hold_o, 1'b0);

    // clean press and release
    man_rst_ni = 1'b0;
    tick_cnt = 0;
    hi_bad = 1'b0;
    while (tick_cnt < DEB) begin
      #1;
      if (sys_rst_no !== 1'b1) hi_bad = 1'b1;
      step();
    end
    #1;
    chk("R7", hi_bad, 1'b0);
    chk("R7", sys_rst_no, 1'b0);
    repeat (30) step();
    #1 chk("R8", sys_rst_no, 1'b0);
    man_rst_ni = 1'b1;
    tick_cnt = 0;
    hi_bad = 1'b0;
    while (tick_cnt < DEB) begin
      #1;
      if (sys_rst_no !== 1'b0) hi_bad = 1'b1;
      step();
    end
    chk("R8", hi_bad, 1'b0);
    wait_release(SH, "R8");

    // random tick density, selector and dip length
    for (int it = 0; it < 25; it++) begin
      tick_den  = 1 + int'($urandom % 3);
      tmo_sel_i = logic'($urandom % 2);
      dip(1 + int'($urandom % 4));
      wait_release(exp_lim(tmo_sel_i), "R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule